// File: doc/BRIEF.md
# DRAM Controller Operating State Machine

This block is the top-level mode sequencer of a DRAM controller. Software moves it between its stable modes with a 3-bit command and a valid strobe. The current mode comes back on a 3-bit status port. The stable modes are memory initialisation, configuration, access and low power. Every move between two stable modes first goes through its own request state. The machine stays in that request state until the downstream logic acknowledges that the move is complete.

The block does not generate DRAM commands itself. When it enters the low-power request state it pulses a self-refresh entry strobe. When it enters the exit request state it pulses a self-refresh exit strobe. The command engine answers both through the shared acknowledge input.

With hardware low power enabled, the machine also enters low power on its own once the controller has been idle for a programmable number of consecutive cycles. It leaves that hardware-entered low power again as soon as traffic appears. Low power never leads straight to configuration: the path is a wakeup to access, then a separate configuration command.

Top module: `dram_op_state_ctrl`

## Requirements
- R1: After reset the status reads 0 (init-mem). The status codes are: 0 init-mem, 1 config, 2 config-req, 3 access, 4 access-req, 5 low-power, 6 low-power-entry-req, 7 low-power-exit-req.
- R2: The command codes are 0 init, 1 cfg, 2 go, 3 sleep and 4 wakeup. A cfg command accepted in init-mem (0) or access (3) moves the status to config-req (2), and then to config (1) once acknowledged.
- R3: A go command in config (1) moves the status to access-req (4), and then to access (3) once acknowledged.
- R4: A sleep command in access moves the status to low-power-entry-req (6) and raises sr_enter_o for exactly one cycle. After the acknowledge, the status is low-power (5).
- R5: A wakeup command in low-power moves the status to low-power-exit-req (7) and raises sr_exit_o for exactly one cycle. After the acknowledge, the status is access (3). A cfg command in low-power leaves the status at 5.
- R6: A request state (2, 4, 6, 7) is reported for at least one cycle. It holds for as long as ack_i stays low.
- R7: A command that is not legal in the current state is ignored and the status does not change. This covers init in any state, codes 5 to 7, and any command in a request state.
- R8: In access with hw_lp_en_i high, IDLE_CYCLES consecutive cycles with idle_i high and no valid command move the status to 6. A busy cycle or a valid command restarts the count.
- R9: A low power entered through R8 is left (status 7, sr_exit_o pulse) when idle_i falls or hw_lp_en_i falls. A low power entered by a sleep command is left only by wakeup.
- R10: ack_i has no effect outside the request states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 3 | Command code |
| hw_lp_en_i | input | 1 | Enables hardware low-power entry and exit |
| idle_i | input | 1 | Controller has no pending traffic |
| ack_i | input | 1 | Downstream completion of the pending request |
| status_o | output | 3 | Current state code |
| sr_enter_o | output | 1 | One-cycle self-refresh entry request |
| sr_exit_o | output | 1 | One-cycle self-refresh exit request |

## Verification
On every cycle the assertions check the following. Request states hold until acknowledged. Config-req is entered only from init-mem or access. Access-req is entered only from config. Access is reached only through one of its request states. Low power never leads directly toward configuration. The two strobes are single-cycle and line up with their request states.

Only the directed scenarios can show the rest: that each illegal command is ignored, the exact idle-cycle count before hardware entry, the count restarting after a busy cycle, and that a sleep-entered low power ignores traffic while a hardware-entered one does not.

// File: rtl/osm_pkg.sv
package osm_pkg;

  typedef enum logic [2:0] {
    ST_INIT_MEM     = 3'd0,
    ST_CONFIG       = 3'd1,
    ST_CONFIG_REQ   = 3'd2,
    ST_ACCESS       = 3'd3,
    ST_ACCESS_REQ   = 3'd4,
    ST_LOW_POWER    = 3'd5,
    ST_LP_ENTRY_REQ = 3'd6,
    ST_LP_EXIT_REQ  = 3'd7
  } osm_state_e;

  localparam logic [2:0] CMD_INIT   = 3'd0;
  localparam logic [2:0] CMD_CFG    = 3'd1;
  localparam logic [2:0] CMD_GO     = 3'd2;
  localparam logic [2:0] CMD_SLEEP  = 3'd3;
  localparam logic [2:0] CMD_WAKEUP = 3'd4;

  typedef enum logic [2:0] {
    MV_NONE,
    MV_CFG,
    MV_GO,
    MV_SLEEP,
    MV_WAKE
  } osm_move_e;

endpackage

// File: rtl/osm_cmd_filter.sv
module osm_cmd_filter
  import osm_pkg::*;
(
  input  osm_state_e state_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  output osm_move_e  move_o
);

  // Only commands legal in the current state become moves; the rest vanish.
  always_comb begin
    move_o = MV_NONE;
    if (cmd_valid_i) begin
      unique case (state_i)
        ST_INIT_MEM:  if (cmd_i == CMD_CFG) move_o = MV_CFG;
        ST_CONFIG:    if (cmd_i == CMD_GO)  move_o = MV_GO;
        ST_ACCESS: begin
          if (cmd_i == CMD_CFG)        move_o = MV_CFG;
          else if (cmd_i == CMD_SLEEP) move_o = MV_SLEEP;
        end
        ST_LOW_POWER: if (cmd_i == CMD_WAKEUP) move_o = MV_WAKE;
        default:      move_o = MV_NONE;
      endcase
    end
  end

endmodule

// File: rtl/osm_idle_timer.sv
module osm_idle_timer
  import osm_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  osm_state_e state_i,
  input  logic       hw_lp_en_i,
  input  logic       idle_i,
  input  logic       cmd_valid_i,
  output logic       idle_hit_o
);

  localparam int unsigned CntW = (IDLE_CYCLES < 2) ? 1 : $clog2(IDLE_CYCLES);
  localparam logic [CntW-1:0] CntLast = CntW'(IDLE_CYCLES - 1);

  logic            qualify;
  logic [CntW-1:0] cnt_q;

  assign qualify    = (state_i == ST_ACCESS) && hw_lp_en_i && idle_i && !cmd_valid_i;
  assign idle_hit_o = qualify && (cnt_q == CntLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!qualify || idle_hit_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/osm_core.sv
module osm_core
  import osm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  osm_move_e  move_i,
  input  logic       idle_hit_i,
  input  logic       hw_lp_en_i,
  input  logic       idle_i,
  input  logic       ack_i,
  output osm_state_e state_o,
  output logic       sr_enter_o,
  output logic       sr_exit_o
);

  osm_state_e state_q, state_d;
  logic       hw_entry_q, hw_entry_d;
  logic       sr_enter_q, sr_exit_q;

  always_comb begin
    state_d    = state_q;
    hw_entry_d = hw_entry_q;
    unique case (state_q)
      ST_INIT_MEM:   if (move_i == MV_CFG) state_d = ST_CONFIG_REQ;
      ST_CONFIG_REQ: if (ack_i) state_d = ST_CONFIG;
      ST_CONFIG:     if (move_i == MV_GO) state_d = ST_ACCESS_REQ;
      ST_ACCESS_REQ: if (ack_i) state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (move_i == MV_CFG) begin
          state_d = ST_CONFIG_REQ;
        end else if (move_i == MV_SLEEP) begin
          state_d    = ST_LP_ENTRY_REQ;
          hw_entry_d = 1'b0;
        end else if (idle_hit_i) begin
          state_d    = ST_LP_ENTRY_REQ;
          hw_entry_d = 1'b1;
        end
      end
      ST_LP_ENTRY_REQ: if (ack_i) state_d = ST_LOW_POWER;
      ST_LOW_POWER: begin
        if (move_i == MV_WAKE) state_d = ST_LP_EXIT_REQ;
        else if (hw_entry_q && (!idle_i || !hw_lp_en_i)) state_d = ST_LP_EXIT_REQ;
      end
      ST_LP_EXIT_REQ: if (ack_i) begin
        state_d    = ST_ACCESS;
        hw_entry_d = 1'b0;
      end
      default: state_d = ST_INIT_MEM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INIT_MEM;
      hw_entry_q <= 1'b0;
      sr_enter_q <= 1'b0;
      sr_exit_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      hw_entry_q <= hw_entry_d;
      sr_enter_q <= (state_d == ST_LP_ENTRY_REQ) && (state_q != ST_LP_ENTRY_REQ);
      sr_exit_q  <= (state_d == ST_LP_EXIT_REQ) && (state_q != ST_LP_EXIT_REQ);
    end
  end

  assign state_o    = state_q;
  assign sr_enter_o = sr_enter_q;
  assign sr_exit_o  = sr_exit_q;

endmodule

// File: rtl/dram_op_state_ctrl.sv
module dram_op_state_ctrl
  import osm_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic       hw_lp_en_i,
  input  logic       idle_i,
  input  logic       ack_i,
  output logic [2:0] status_o,
  output logic       sr_enter_o,
  output logic       sr_exit_o
);

  osm_state_e state;
  osm_move_e  move;
  logic       idle_hit;

  osm_cmd_filter i_filter (
    .state_i     (state),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .move_o      (move)
  );

  osm_idle_timer #(
    .IDLE_CYCLES (IDLE_CYCLES)
  ) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .hw_lp_en_i  (hw_lp_en_i),
    .idle_i      (idle_i),
    .cmd_valid_i (cmd_valid_i),
    .idle_hit_o  (idle_hit)
  );

  osm_core i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .move_i     (move),
    .idle_hit_i (idle_hit),
    .hw_lp_en_i (hw_lp_en_i),
    .idle_i     (idle_i),
    .ack_i      (ack_i),
    .state_o    (state),
    .sr_enter_o (sr_enter_o),
    .sr_exit_o  (sr_exit_o)
  );

  assign status_o = state;

endmodule

// File: rtl/osm_checker.sv
module osm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic [2:0] status_i,
  input logic       sr_enter_i,
  input logic       sr_exit_i
);

  logic in_req;
  assign in_req = (status_i == 3'd2) || (status_i == 3'd4) ||
                  (status_i == 3'd6) || (status_i == 3'd7);

  AST_REQ_HOLDS_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_req && !ack_i) |=> $stable(status_i)); // R6

  AST_CFG_REQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i != 3'd2 && status_i != 3'd0 && status_i != 3'd3) |=> (status_i != 3'd2)); // R2

  AST_GO_REQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i != 3'd4 && status_i != 3'd1) |=> (status_i != 3'd4)); // R3

  AST_ACCESS_VIA_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i != 3'd3 && status_i != 3'd4 && status_i != 3'd7) |=> (status_i != 3'd3)); // R6

  AST_LP_NOT_TO_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'd5) |=> (status_i == 3'd5 || status_i == 3'd7)); // R5

  AST_ENTER_STROBE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_enter_i |-> (status_i == 3'd6)); // R4

  AST_ENTER_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_enter_i |=> !sr_enter_i); // R4

  AST_EXIT_STROBE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_exit_i |-> (status_i == 3'd7)); // R5

  AST_EXIT_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_exit_i |=> !sr_exit_i); // R5

endmodule

bind dram_op_state_ctrl osm_checker i_osm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .status_i   (status_o),
  .sr_enter_i (sr_enter_o),
  .sr_exit_i  (sr_exit_o)
);

// File: tb/test_dram_op_state_ctrl.sv
`timescale 1ns/100ps
module test_dram_op_state_ctrl;

  localparam int unsigned IDLE_N = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic       hw_lp_en_i = 1'b0;
  logic       idle_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [2:0] status_o;
  logic       sr_enter_o;
  logic       sr_exit_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dram_op_state_ctrl #(.IDLE_CYCLES(IDLE_N)) i_dram_op_state_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .hw_lp_en_i  (hw_lp_en_i),
    .idle_i      (idle_i),
    .ack_i       (ack_i),
    .status_o    (status_o),
    .sr_enter_o  (sr_enter_o),
    .sr_exit_o   (sr_exit_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    cmd_i = c;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_o, 0);
    chk("R1 reset enter strobe", sr_enter_o, 0);
    chk("R1 reset exit strobe", sr_exit_o, 0);
  endtask

  task automatic t_init_illegal();
    send(3'd2); chk("R7 go in init-mem", status_o, 0);
    send(3'd3); chk("R7 sleep in init-mem", status_o, 0);
    send(3'd4); chk("R7 wakeup in init-mem", status_o, 0);
    send(3'd0); chk("R7 init in init-mem", status_o, 0);
    send(3'd6); chk("R7 code 6 in init-mem", status_o, 0);
    pulse_ack(); chk("R10 ack in init-mem", status_o, 0);
  endtask

  task automatic t_cfg_from_init();
    send(3'd1); chk("R2 cfg from init-mem", status_o, 2);
    idle_cycles(3); chk("R6 config-req held", status_o, 2);
    send(3'd2); chk("R7 go in config-req", status_o, 2);
    pulse_ack(); chk("R2 config after ack", status_o, 1);
  endtask

  task automatic t_cfg_illegal();
    send(3'd3); chk("R7 sleep in config", status_o, 1);
    send(3'd4); chk("R7 wakeup in config", status_o, 1);
    send(3'd1); chk("R7 cfg in config", status_o, 1);
    send(3'd7); chk("R7 code 7 in config", status_o, 1);
    pulse_ack(); chk("R10 ack in config", status_o, 1);
  endtask

  task automatic t_go();
    send(3'd2); chk("R3 go from config", status_o, 4);
    idle_cycles(2); chk("R6 access-req held", status_o, 4);
    pulse_ack(); chk("R3 access after ack", status_o, 3);
    pulse_ack(); chk("R10 ack in access", status_o, 3);
  endtask

  task automatic t_sleep_wake();
    send(3'd3);
    chk("R4 sleep to entry-req", status_o, 6);
    chk("R4 enter strobe high", sr_enter_o, 1);
    @(negedge clk);
    chk("R4 enter strobe one cycle", sr_enter_o, 0);
    chk("R6 entry-req held", status_o, 6);
    pulse_ack(); chk("R4 low-power after ack", status_o, 5);
    send(3'd1); chk("R5 cfg refused in low-power", status_o, 5);
    send(3'd2); chk("R7 go in low-power", status_o, 5);
    idle_i = 1'b0; idle_cycles(3);
    chk("R9 sleep-entered stays", status_o, 5);
    send(3'd4);
    chk("R5 wakeup to exit-req", status_o, 7);
    chk("R5 exit strobe high", sr_exit_o, 1);
    @(negedge clk);
    chk("R5 exit strobe one cycle", sr_exit_o, 0);
    pulse_ack(); chk("R5 access after exit ack", status_o, 3);
  endtask

  task automatic t_cfg_from_access();
    send(3'd1); chk("R2 cfg from access", status_o, 2);
    pulse_ack(); chk("R2 config from access", status_o, 1);
    send(3'd2); pulse_ack(); chk("R3 back to access", status_o, 3);
  endtask

  task automatic t_hw_lp();
    hw_lp_en_i = 1'b1;
    idle_i = 1'b1;
    idle_cycles(IDLE_N - 1);
    idle_i = 1'b0;
    @(negedge clk);
    chk("R8 busy restarts count", status_o, 3);
    idle_i = 1'b1;
    idle_cycles(IDLE_N - 2);
    send(3'd0);
    idle_cycles(IDLE_N - 1);
    chk("R8 command restarts count", status_o, 3);
    @(negedge clk);
    chk("R8 hardware entry", status_o, 6);
    chk("R8 enter strobe", sr_enter_o, 1);
    pulse_ack(); chk("R8 hardware low-power", status_o, 5);
    idle_cycles(2); chk("R9 stays while idle", status_o, 5);
    idle_i = 1'b0;
    @(negedge clk);
    chk("R9 busy exits low-power", status_o, 7);
    chk("R9 exit strobe", sr_exit_o, 1);
    pulse_ack(); chk("R9 back in access", status_o, 3);
    idle_i = 1'b1;
    idle_cycles(IDLE_N);
    chk("R8 second hardware entry", status_o, 6);
    pulse_ack();
    hw_lp_en_i = 1'b0;
    @(negedge clk);
    chk("R9 enable drop exits", status_o, 7);
    pulse_ack(); chk("R9 access after enable drop", status_o, 3);
    idle_cycles(IDLE_N + 2);
    chk("R8 no entry while disabled", status_o, 3);
    idle_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_init_illegal();
    t_cfg_from_init();
    t_cfg_illegal();
    t_go();
    t_sleep_wake();
    t_cfg_from_access();
    t_hw_lp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule